// File: doc/BRIEF.md
# Byte-Wide Clock Register Window

This block is a byte-wide slave on an asynchronous-SRAM-style bus. It is sampled on the system clock and decodes active-low chip-select, output-enable and write-enable strobes. Most of the 15-bit address space is plain byte storage. The eight highest addresses hold the clock registers. These registers do not count time themselves. They are holding cells that an external counter chain refreshes once per second through a snapshot bus. In the other direction, the block hands user-set values back to the counters with a single load strobe.

The lowest clock address is a control byte. It holds two freeze bits and the calibration setting, and the calibration setting drives `cal_ctrl` straight out to the calibration logic. The read freeze stops the refresh so that software can read a consistent time. The write freeze also stops the refresh, and clearing it sends all seven time bytes to the counters at once. An input flag models power-fail protection: while it is set, the block releases the data bus and ignores writes. The ordinary storage has `2**RAM_AW` bytes, and the address is reduced to its low `RAM_AW` bits when that storage is addressed.

The bus side is a state machine with four states:
- IDLE: chip select is high.
- READ: chip select is low and write enable is high.
- WRITE: chip select and write enable are both low.
- LOCK: the protect flag is set.

Every edge moves the machine to the state that the sampled strobes select, and LOCK has priority. On an exit from WRITE that does not go to LOCK, the write is committed.

The clock side is a second state machine:
- RUN goes to HOLD when either freeze bit is set. Otherwise a tick moves it to PEND.
- PEND copies the snapshot and goes to HOLD if frozen, or to RUN if not.
- HOLD goes to COMMIT when the write-freeze bit falls. Otherwise it stays in HOLD while frozen and returns to RUN when free.
- COMMIT raises the load strobe and goes to HOLD or RUN in the same way as PEND.

Top module: `rtc_byte_window`

## Requirements
- R1: An address whose upper twelve bits are not all ones reaches byte storage, indexed by its low `RAM_AW` bits. A byte written there reads back unchanged.
- R2: Read mode is chip select low with write enable high. The edge that samples read mode loads `bus_rdata` from the addressed location. `bus_drive` is 1 after that edge if output enable was sampled low at the same edge.
- R3: A write lands exactly once, on the first edge that sees chip select or write enable high after write mode. It uses the address and data sampled in the last write-mode cycle, and it lands the same way whichever strobe rises first.
- R4: `bus_drive` is 0 whenever the last sampled state was write mode, deselect, or output enable high.
- R5: While `prot_hold` is sampled high, `bus_drive` is 0 and no write lands. A write still in progress when `prot_hold` rises is discarded.
- R6: The control byte is at 7FF8h: bit 7 is the write freeze, bit 6 is the read freeze, and bits 5:0 drive `cal_ctrl` (bit 5 is the sign, bits 4:0 the magnitude). Offsets 7FF9h–7FFFh hold time bytes 0–6. Time byte k maps to `snap_time[8k+7:8k]` and `load_time[8k+7:8k]`. After reset all eight bytes are 0.
- R7: With both freeze bits clear, a `sec_tick` sampled at one edge replaces all seven time bytes from `snap_time` at the following edge.
- R8: While the read-freeze bit is 1, ticks are ignored and the time bytes keep their values.
- R9: Setting the write-freeze bit also stops the refresh. Clearing it raises `load_pulse` for exactly one cycle, starting one edge after the write that cleared it, with `load_time` carrying the seven time bytes.
- R10: A tick accepted while unfrozen still completes its copy when a freeze bit is set at the same edge that accepts the tick.
- R11: Once the freeze bits are clear again, the next tick refreshes the time bytes.
- R12: In time byte 3 (7FFCh), bits 6 (test) and 5 (century enable) can be written at any time and survive a refresh. The refresh takes all other bits of that byte from the snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_drive is 1 |
| bus_drive | output | 1 | Data output enable; 0 models high impedance |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| prot_hold | input | 1 | Power-fail protect: forced deselect |
| sec_tick | input | 1 | Once-per-second refresh request |
| snap_time | input | 56 | Live counter values, seven bytes |
| load_pulse | output | 1 | One-cycle strobe to load counters |
| load_time | output | 56 | Values for the counters, seven bytes |
| cal_ctrl | output | 6 | Calibration sign and magnitude |

## Verification
Read data and `bus_drive` are due after the edge that samples read mode, so they are compared one half-cycle after that edge. A write becomes visible after the edge that ends write mode. A refresh lands one edge after the tick is sampled. The load strobe follows two edges after the write that clears the write freeze. A behavioural model in the bench advances on each rising edge with these latencies. Its predictions are compared at every falling edge, and directed reads add hand-computed expected values.

// File: rtl/rtcw_pkg.sv
package rtcw_pkg;
    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned CK_REGS   = 8;
    localparam int unsigned TIME_REGS = CK_REGS - 1;
    localparam int unsigned OFF_W     = $clog2(CK_REGS);
    localparam int unsigned BIT_WFRZ  = 7;
    localparam int unsigned BIT_RFRZ  = 6;
    localparam int unsigned CAL_W     = 6;
    localparam int unsigned DAY_OFF   = 4;
    localparam logic [7:0]  DAY_KEEP  = 8'h60;

    typedef enum logic [1:0] {BUS_IDLE, BUS_READ, BUS_WRITE, BUS_LOCK} bus_state_t;
    typedef enum logic [1:0] {CK_RUN, CK_PEND, CK_HOLD, CK_COMMIT} ck_state_t;
endpackage

// File: rtl/rtcw_bus_fsm.sv
module rtcw_bus_fsm
    import rtcw_pkg::*;
#(
    parameter int unsigned ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              prot_hold,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic              rd_sample,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              drive
);
    bus_state_t st, nxt;
    logic       oe_q;

    always_comb begin
        if (prot_hold)           nxt = BUS_LOCK;
        else if (!ce_n && !we_n) nxt = BUS_WRITE;
        else if (!ce_n)          nxt = BUS_READ;
        else                     nxt = BUS_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= BUS_IDLE;
            oe_q    <= 1'b1;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            st   <= nxt;
            oe_q <= oe_n;
            if (nxt == BUS_WRITE) begin
                wr_addr <= addr;
                wr_data <= wdata;
            end
        end
    end

    always_comb begin
        drive     = 1'b0;
        wr_en     = 1'b0;
        rd_sample = (nxt == BUS_READ);
        unique case (st)
            BUS_IDLE:  ;
            BUS_READ:  drive = !oe_q;
            BUS_WRITE: wr_en = (nxt != BUS_WRITE) && !prot_hold;
            BUS_LOCK:  ;
        endcase
    end

    p_commit_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);
    p_lock_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        prot_hold |=> !drive);
    p_write_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !we_n) |=> !drive);
endmodule

// File: rtl/rtcw_ram.sv
module rtcw_ram
    import rtcw_pkg::*;
#(
    parameter int unsigned RAM_AW = 10
) (
    input  logic              clk,
    input  logic              we,
    input  logic [RAM_AW-1:0] waddr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [RAM_AW-1:0] raddr,
    output logic [BYTE_W-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << RAM_AW;
    logic [BYTE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/rtcw_clk_regs.sv
module rtcw_clk_regs
    import rtcw_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          tick,
    input  logic [TIME_REGS*BYTE_W-1:0]   snap,
    input  logic                          wr_en,
    input  logic [OFF_W-1:0]              wr_off,
    input  logic [BYTE_W-1:0]             wr_data,
    input  logic [OFF_W-1:0]              rd_off,
    output logic [BYTE_W-1:0]             rd_data,
    output logic [CAL_W-1:0]              cal,
    output logic                          load_pulse,
    output logic [TIME_REGS*BYTE_W-1:0]   load_time
);
    logic [BYTE_W-1:0] regs [CK_REGS];
    ck_state_t st, nxt;
    logic wbit_q, frz, wr_fall, copy;

    assign frz     = regs[0][BIT_WFRZ] | regs[0][BIT_RFRZ];
    assign wr_fall = wbit_q & ~regs[0][BIT_WFRZ];

    always_comb begin
        unique case (st)
            CK_RUN:    nxt = frz ? CK_HOLD : (tick ? CK_PEND : CK_RUN);
            CK_PEND:   nxt = frz ? CK_HOLD : CK_RUN;
            CK_HOLD:   nxt = wr_fall ? CK_COMMIT : (frz ? CK_HOLD : CK_RUN);
            CK_COMMIT: nxt = frz ? CK_HOLD : CK_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= CK_RUN;
            wbit_q <= 1'b0;
        end else begin
            st     <= nxt;
            wbit_q <= regs[0][BIT_WFRZ];
        end
    end

    always_comb begin
        copy       = 1'b0;
        load_pulse = 1'b0;
        unique case (st)
            CK_RUN:    ;
            CK_PEND:   copy = 1'b1;
            CK_HOLD:   ;
            CK_COMMIT: load_pulse = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < CK_REGS; i++) regs[i] <= '0;
        end else begin
            if (copy) begin
                for (int k = 1; k < CK_REGS; k++) begin
                    if (k == DAY_OFF)
                        regs[k] <= (regs[k] & DAY_KEEP) | (snap[(k-1)*BYTE_W +: BYTE_W] & ~DAY_KEEP);
                    else
                        regs[k] <= snap[(k-1)*BYTE_W +: BYTE_W];
                end
            end
            if (wr_en) regs[wr_off] <= wr_data;
        end
    end

    for (genvar g = 0; g < TIME_REGS; g++) begin : g_load
        assign load_time[g*BYTE_W +: BYTE_W] = regs[g+1];
    end

    assign rd_data = regs[rd_off];
    assign cal     = regs[0][CAL_W-1:0];

    p_load_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
        load_pulse |=> !load_pulse);
    p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CK_HOLD && !wr_en) |=> $stable(load_time));
    p_copy_sec_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CK_PEND && !wr_en) |=> (load_time[BYTE_W-1:0] == $past(snap[BYTE_W-1:0])));
endmodule

// File: rtl/rtc_byte_window.sv
module rtc_byte_window
    import rtcw_pkg::*;
#(
    parameter int unsigned ADDR_W = 15,
    parameter int unsigned RAM_AW = 10
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [BYTE_W-1:0]           bus_wdata,
    output logic [BYTE_W-1:0]           bus_rdata,
    output logic                        bus_drive,
    input  logic                        ce_n,
    input  logic                        oe_n,
    input  logic                        we_n,
    input  logic                        prot_hold,
    input  logic                        sec_tick,
    input  logic [TIME_REGS*BYTE_W-1:0] snap_time,
    output logic                        load_pulse,
    output logic [TIME_REGS*BYTE_W-1:0] load_time,
    output logic [CAL_W-1:0]            cal_ctrl
);
    logic              rd_sample, wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [BYTE_W-1:0] wr_data, ram_rd, ck_rd, rdata_q;
    logic              rd_is_ck, wr_is_ck, ram_we, ck_we;

    assign rd_is_ck = &bus_addr[ADDR_W-1:OFF_W];
    assign wr_is_ck = &wr_addr[ADDR_W-1:OFF_W];
    assign ram_we   = wr_en & ~wr_is_ck;
    assign ck_we    = wr_en & wr_is_ck;

    rtcw_bus_fsm #(.ADDR_W(ADDR_W)) u_bus (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .prot_hold(prot_hold), .addr(bus_addr), .wdata(bus_wdata),
        .rd_sample(rd_sample), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .drive(bus_drive)
    );

    rtcw_ram #(.RAM_AW(RAM_AW)) u_ram (
        .clk(clk), .we(ram_we), .waddr(wr_addr[RAM_AW-1:0]), .wdata(wr_data),
        .raddr(bus_addr[RAM_AW-1:0]), .rdata(ram_rd)
    );

    rtcw_clk_regs u_ck (
        .clk(clk), .rst_n(rst_n), .tick(sec_tick), .snap(snap_time),
        .wr_en(ck_we), .wr_off(wr_addr[OFF_W-1:0]), .wr_data(wr_data),
        .rd_off(bus_addr[OFF_W-1:0]), .rd_data(ck_rd), .cal(cal_ctrl),
        .load_pulse(load_pulse), .load_time(load_time)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         rdata_q <= '0;
        else if (rd_sample) rdata_q <= rd_is_ck ? ck_rd : ram_rd;
    end

    assign bus_rdata = rdata_q;

    p_cal_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ck_we && wr_addr[OFF_W-1:0] == '0) |=> (cal_ctrl == $past(wr_data[CAL_W-1:0])));
    p_no_ram_write_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        prot_hold |-> !ram_we && !ck_we);
endmodule

// File: tb/rtc_byte_window_tb.sv
module rtc_byte_window_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        bus_drive;
    logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic        prot_hold = 1'b0, sec_tick = 1'b0;
    logic [55:0] snap_time = '0;
    logic        load_pulse;
    logic [55:0] load_time;
    logic [5:0]  cal_ctrl;

    int checks = 0, fails = 0, cyc = 0;
    bit done = 0;

    always #5 clk = ~clk;

    rtc_byte_window dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_drive(bus_drive), .ce_n(ce_n), .oe_n(oe_n),
        .we_n(we_n), .prot_hold(prot_hold), .sec_tick(sec_tick),
        .snap_time(snap_time), .load_pulse(load_pulse), .load_time(load_time),
        .cal_ctrl(cal_ctrl)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int          m_st, m_ck;
    bit          m_oe, m_wb;
    logic [14:0] m_wa;
    logic [7:0]  m_wd;
    logic [7:0]  m_mem [int];
    logic [7:0]  m_ck_b [8];
    logic [7:0]  exp_rd;
    bit          exp_drive, exp_load;

    function automatic logic [7:0] m_read(input logic [14:0] a);
        if (&a[14:3]) return m_ck_b[a[2:0]];
        if (m_mem.exists(int'(a[9:0]))) return m_mem[int'(a[9:0])];
        return 8'hxx;
    endfunction

    function automatic logic [55:0] m_pack();
        logic [55:0] v;
        for (int k = 0; k < 7; k++) v[k*8 +: 8] = m_ck_b[k+1];
        return v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_ck = 0; m_oe = 1; m_wb = 0; m_wa = '0; m_wd = '0;
            for (int i = 0; i < 8; i++) m_ck_b[i] = 8'h00;
            exp_rd = 8'h00; exp_drive = 0; exp_load = 0;
        end else begin
            int  nst, nck;
            bit  cm, frz, wf;
            nst = prot_hold ? 3 : (!ce_n && !we_n) ? 2 : !ce_n ? 1 : 0;
            cm  = (m_st == 2) && (nst != 2) && !prot_hold;
            frz = m_ck_b[0][7] | m_ck_b[0][6];
            wf  = m_wb && !m_ck_b[0][7];
            case (m_ck)
                0: nck = frz ? 2 : (sec_tick ? 1 : 0);
                1: nck = frz ? 2 : 0;
                2: nck = wf ? 3 : (frz ? 2 : 0);
                default: nck = frz ? 2 : 0;
            endcase
            if (nst == 1) exp_rd = m_read(bus_addr);
            m_wb = m_ck_b[0][7];
            if (m_ck == 1)
                for (int k = 1; k < 8; k++)
                    m_ck_b[k] = (k == 4) ? ((m_ck_b[k] & 8'h60) | (snap_time[(k-1)*8 +: 8] & 8'h9F))
                                         : snap_time[(k-1)*8 +: 8];
            if (cm) begin
                if (&m_wa[14:3]) m_ck_b[m_wa[2:0]] = m_wd;
                else m_mem[int'(m_wa[9:0])] = m_wd;
            end
            if (nst == 2) begin m_wa = bus_addr; m_wd = bus_wdata; end
            m_st = nst; m_oe = oe_n; m_ck = nck;
            exp_drive = (m_st == 1) && !m_oe;
            exp_load  = (m_ck == 3);
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(bus_drive === exp_drive, "R4 drive", 64'(bus_drive), 64'(exp_drive));
            if (exp_drive && !$isunknown(exp_rd))
                chk(bus_rdata === exp_rd, "R2 rdata", 64'(bus_rdata), 64'(exp_rd));
            chk(load_pulse === exp_load, "R9 load_pulse", 64'(load_pulse), 64'(exp_load));
            if (exp_load)
                chk(load_time === m_pack(), "R9 load_time", 64'(load_time), 64'(m_pack()));
            chk(cal_ctrl === m_ck_b[0][5:0], "R6 cal", 64'(cal_ctrl), 64'(m_ck_b[0][5:0]));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=0", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // mode 0: write enable rises first; mode 1: chip select rises first
    task automatic bus_wr(input logic [14:0] a, input logic [7:0] d, input int mode = 0, input bit tick_end = 0);
        @(negedge clk); bus_addr = a; bus_wdata = d; ce_n = 0; we_n = 0; oe_n = 1;
        @(negedge clk);
        @(negedge clk);
        if (tick_end) sec_tick = 1;
        if (mode == 0) we_n = 1; else ce_n = 1;
        @(negedge clk); ce_n = 1; we_n = 1; sec_tick = 0;
    endtask

    task automatic bus_rd(input logic [14:0] a, input logic [7:0] e, input string tag);
        @(negedge clk); bus_addr = a; ce_n = 0; we_n = 1; oe_n = 0;
        @(negedge clk);
        chk(bus_drive === 1'b1, tag, 64'(bus_drive), 64'd1);
        chk(bus_rdata === e, tag, 64'(bus_rdata), 64'(e));
        ce_n = 1; oe_n = 1;
    endtask

    task automatic tick1();
        @(negedge clk); sec_tick = 1;
        @(negedge clk); sec_tick = 0;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(bus_drive === 1'b0, "R6 reset drive", 64'(bus_drive), 64'd0);
        chk(load_pulse === 1'b0, "R6 reset load", 64'(load_pulse), 64'd0);
        chk(cal_ctrl === 6'd0, "R6 reset cal", 64'(cal_ctrl), 64'd0);
        bus_rd(15'h7FF8, 8'h00, "R6 reset ctrl");
        bus_rd(15'h7FFC, 8'h00, "R6 reset day");

        // R1 / R3: storage with both write endings
        bus_wr(15'h0010, 8'hA5, 0);
        bus_wr(15'h0123, 8'h3C, 1);
        bus_wr(15'h7FF7, 8'hE1, 1);
        bus_rd(15'h0010, 8'hA5, "R1 ram 0010");
        bus_rd(15'h0123, 8'h3C, "R3 ce-first write");
        bus_rd(15'h7FF7, 8'hE1, "R1 ram 7FF7");

        // R4: output enable high, then write mode with output enable low
        @(negedge clk); bus_addr = 15'h0010; ce_n = 0; we_n = 1; oe_n = 1;
        @(negedge clk); chk(bus_drive === 1'b0, "R4 oe high", 64'(bus_drive), 64'd0);
        we_n = 0; oe_n = 0; bus_wdata = 8'hA5;
        @(negedge clk); chk(bus_drive === 1'b0, "R4 write mode", 64'(bus_drive), 64'd0);
        ce_n = 1; we_n = 1; oe_n = 1;

        // R5: write cut off by protect, read under protect
        @(negedge clk); bus_addr = 15'h0010; bus_wdata = 8'h5A; ce_n = 0; we_n = 0;
        @(negedge clk); prot_hold = 1;
        @(negedge clk); ce_n = 1; we_n = 1;
        @(negedge clk); bus_addr = 15'h0123; ce_n = 0; oe_n = 0;
        @(negedge clk); chk(bus_drive === 1'b0, "R5 locked read", 64'(bus_drive), 64'd0);
        bus_wdata = 8'h77; we_n = 0;
        @(negedge clk); ce_n = 1; we_n = 1; oe_n = 1;
        @(negedge clk); prot_hold = 0;
        bus_rd(15'h0010, 8'hA5, "R5 write dropped");
        bus_rd(15'h0123, 8'h3C, "R5 locked write ignored");

        // R7 / R6: refresh and byte order
        snap_time = 56'h24_12_31_05_23_59_58;
        tick1();
        bus_rd(15'h7FF9, 8'h58, "R7 seconds");
        bus_rd(15'h7FFC, 8'h05, "R6 byte3");
        bus_rd(15'h7FFF, 8'h24, "R7 byte6");

        // R8 / R11
        bus_wr(15'h7FF8, 8'h40);
        snap_time = 56'h25_01_01_03_00_00_07;
        tick1();
        bus_rd(15'h7FF9, 8'h58, "R8 frozen");
        bus_wr(15'h7FF8, 8'h00);
        tick1();
        bus_rd(15'h7FF9, 8'h07, "R11 resumed");

        // R10: freeze set on the edge that accepts a tick
        snap_time[7:0] = 8'h11;
        bus_wr(15'h7FF8, 8'h40, 0, 1);
        bus_rd(15'h7FF9, 8'h11, "R10 copy completed");
        snap_time[7:0] = 8'h22;
        tick1();
        bus_rd(15'h7FF9, 8'h11, "R10 frozen after");
        bus_wr(15'h7FF8, 8'h00);

        // R9: set time under write freeze
        bus_wr(15'h7FF8, 8'h80);
        bus_wr(15'h7FF9, 8'h30); bus_wr(15'h7FFA, 8'h45); bus_wr(15'h7FFB, 8'h12);
        bus_wr(15'h7FFC, 8'h02); bus_wr(15'h7FFD, 8'h15); bus_wr(15'h7FFE, 8'h06);
        bus_wr(15'h7FFF, 8'h99);
        tick1();
        bus_rd(15'h7FF9, 8'h30, "R9 held");
        begin
            int seen = 0;
            logic [55:0] got = '0;
            bus_wr(15'h7FF8, 8'h00);
            for (int i = 0; i < 4; i++) begin
                @(negedge clk);
                if (load_pulse) begin seen++; got = load_time; end
            end
            chk(seen == 1, "R9 pulse count", 64'(seen), 64'd1);
            chk(got === 56'h99_06_15_02_12_45_30, "R9 load value", 64'(got), 64'h99_06_15_02_12_45_30);
        end

        // R12: test and century-enable bits survive refresh
        bus_wr(15'h7FFC, 8'h60);
        snap_time = 56'h25_01_01_13_00_00_07;
        tick1();
        bus_rd(15'h7FFC, 8'h73, "R12 day keep");

        // R6: calibration field
        bus_wr(15'h7FF8, 8'h25);
        @(negedge clk);
        chk(cal_ctrl === 6'h25, "R6 cal out", 64'(cal_ctrl), 64'h25);
        bus_rd(15'h7FF8, 8'h25, "R6 ctrl readback");

        repeat (3) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule